// File: doc/BRIEF.md
# Translation-Off Access Attribute and Fetch-Window Unit

This unit sits ahead of an address translation path. While translation is switched off (bypass mode) it answers every load, store and instruction fetch by itself. The physical address is the incoming address unchanged. Memory attributes are chosen separately for data and for instruction accesses. No permission check is made and nothing aborts. Each instruction fetch is also tested against a two-page window that follows the sequential program flow. While translation is on, it flags every request as pass-through, forwards the address and leaves its own attribute fields at zero.

Software reaches it through a small configuration write port. That port holds a control register (translation enable, instruction cacheability, remap enable) and a process-ID register. An error flag warns when the process ID is non-zero in bypass mode. TLB-invalidate and cache-maintenance requests are accepted in either mode. In bypass mode they carry the flat address and are marked global. Every response appears one clock after its request is accepted. A request uses the mode that the control register held when the request was accepted.

Top module: `mmu_bypass_unit`

## Requirements
- R1: After synchronous reset, ctl_state is 3'b000 (bypass mode, instruction caching off, remap off), pid_err is 0, and rsp_valid and mnt_valid are 0.
- R2: In bypass mode a request accepted in cycle t gives rsp_valid in cycle t+1, with rsp_paddr equal to req_addr bit for bit and rsp_passthru 0.
- R3: In bypass mode a data access (req_is_instr 0) gets rsp_mem_type 2'b00 (strongly-ordered), rsp_inner and rsp_outer 2'b00 (non-cacheable), rsp_shareable 1 and rsp_fetch_ok 1.
- R4: In bypass mode with the instruction-cacheability bit (ctl_state[1]) at 0, every instruction access gets rsp_inner and rsp_outer 2'b00 (non-cacheable).
- R5: In bypass mode with ctl_state[1] at 1, every instruction access gets rsp_inner and rsp_outer 2'b10 (write-through, no write-allocate).
- R6: In bypass mode every instruction access gets rsp_mem_type 2'b10 (Normal) and rsp_shareable 0, whatever ctl_state[1] holds.
- R7: rsp_abort is never 1, in either mode, for any address, and also for an instruction fetch outside the window.
- R8: The process ID is written with cfg_sel 1 (cfg_wdata holds the whole ID). pid_err is 1 in the cycle after any configuration write that leaves bypass mode active with a non-zero process ID. It is 0 in the cycle after a write that leaves the ID at zero or turns translation on.
- R9: For an instruction access in bypass mode, rsp_fetch_ok is 1 exactly when req_addr[ADDR_W-1:12] equals seq_page or seq_page+1, taken modulo 2^(ADDR_W-12), so the top page is followed by page 0.
- R10: A maintenance request is answered one cycle later with mnt_valid 1, mnt_tlb and mnt_addr equal to the request. In bypass mode mnt_global is 1 and mnt_passthru 0. With translation on, mnt_global is 0 and mnt_passthru 1.
- R11: With translation on, a response has rsp_passthru 1, rsp_paddr equal to req_addr, and rsp_mem_type, rsp_inner, rsp_outer, rsp_shareable and rsp_fetch_ok all 0.
- R12: A write with cfg_sel 0 sets the control register: bit 0 is translation enable, bit 1 is instruction cacheability, bit 2 is remap enable, and ctl_state = {bit2, bit1, bit0}. A request accepted on the same edge as that write uses the previous mode. The next request uses the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the control register, 1 selects the process ID |
| cfg_wdata | input | PID_W | Configuration write data |
| req_valid | input | 1 | Access request valid |
| req_is_instr | input | 1 | 1 for instruction fetch, 0 for data access |
| req_addr | input | ADDR_W | Modified virtual address of the access |
| seq_page | input | ADDR_W-12 | Page number of the current sequential fetch address |
| mnt_req_valid | input | 1 | Maintenance request valid |
| mnt_req_tlb | input | 1 | 1 for TLB invalidate, 0 for cache maintenance |
| mnt_req_addr | input | ADDR_W | Maintenance address |
| ctl_state | output | 3 | Control register {remap, icache, translate} |
| pid_err | output | 1 | Non-zero process ID while in bypass mode |
| rsp_valid | output | 1 | Response valid |
| rsp_is_instr | output | 1 | Echo of the request type |
| rsp_paddr | output | ADDR_W | Physical (or forwarded) address |
| rsp_mem_type | output | 2 | 00 strongly-ordered, 01 device, 10 Normal |
| rsp_inner | output | 2 | Inner policy: 00 non-cacheable, 10 write-through no allocate |
| rsp_outer | output | 2 | Outer policy, same encoding |
| rsp_shareable | output | 1 | Shareable attribute |
| rsp_passthru | output | 1 | Request belongs to the translation path |
| rsp_fetch_ok | output | 1 | Fetch lies inside the permitted window |
| rsp_abort | output | 1 | Abort indication (never raised by this unit) |
| mnt_valid | output | 1 | Maintenance response valid |
| mnt_tlb | output | 1 | Echo of maintenance type |
| mnt_addr | output | ADDR_W | Maintenance address |
| mnt_global | output | 1 | All entries treated as global |
| mnt_passthru | output | 1 | Maintenance forwarded to translation path |

## Verification
The bench aims at the window edges: the same page, the next page, the page just below, two pages ahead, and the wrap from the top page to page 0. A design that compared the full address would reject the next page. One without modulo arithmetic would refuse the wrap. It writes the control register on the same edge as a request, so a design that used the new mode too early would return pass-through one access too soon. It also switches the process ID and the translation enable in both orders. A design that looked only at the ID write would miss an error caused by turning translation off, or would keep the flag set after translation came back on.

// File: rtl/mmu_bypass_pkg.sv
package mmu_bypass_pkg;

  typedef enum logic [1:0] {
    MT_STRONG = 2'b00,
    MT_DEVICE = 2'b01,
    MT_NORMAL = 2'b10
  } mem_type_e;

  typedef enum logic [1:0] {
    CP_NONCACHE = 2'b00,
    CP_WB_WA    = 2'b01,
    CP_WT_NOWA  = 2'b10,
    CP_WB_NOWA  = 2'b11
  } cache_pol_e;

  typedef struct packed {
    logic remap;
    logic icache;
    logic xlat;
  } ctrl_t;

  typedef struct packed {
    mem_type_e  mtype;
    cache_pol_e inner;
    cache_pol_e outer;
    logic       shareable;
  } attr_t;

endpackage

// File: rtl/mbu_ctrl_regs.sv
module mbu_ctrl_regs
  import mmu_bypass_pkg::*;
#(
  parameter int PID_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             sel,
  input  logic [PID_W-1:0] wdata,
  output ctrl_t            ctrl_q,
  output logic             err_q
);

  logic [PID_W-1:0] pid_q;
  ctrl_t            ctrl_d;
  logic [PID_W-1:0] pid_d;

  always_comb begin
    ctrl_d = ctrl_q;
    pid_d  = pid_q;
    if (wr_en) begin
      if (sel) pid_d = wdata;
      else     ctrl_d = ctrl_t'(wdata[2:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pid_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pid_q  <= pid_d;
      err_q  <= !ctrl_d.xlat && (pid_d != '0);
    end
  end

  AST_RESET_BYPASS: assert property (@(posedge clk) rst |=> (ctrl_q == '0 && !err_q)); // R1
  AST_PID_ERR_SET: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel && wdata != '0 && !ctrl_q.xlat) |=> err_q); // R8
  AST_PID_ERR_XLAT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !sel && wdata[0]) |=> !err_q); // R8

endmodule

// File: rtl/mbu_attr_sel.sv
module mbu_attr_sel
  import mmu_bypass_pkg::*;
(
  input  logic  is_instr,
  input  logic  icache,
  output attr_t attr
);

  always_comb begin
    if (is_instr) begin
      attr.mtype     = MT_NORMAL;
      attr.inner     = icache ? CP_WT_NOWA : CP_NONCACHE;
      attr.outer     = icache ? CP_WT_NOWA : CP_NONCACHE;
      attr.shareable = 1'b0;
    end else begin
      attr.mtype     = MT_STRONG;
      attr.inner     = CP_NONCACHE;
      attr.outer     = CP_NONCACHE;
      attr.shareable = 1'b1;
    end
  end

endmodule

// File: rtl/mbu_fetch_window.sv
module mbu_fetch_window #(
  parameter int PN_W = 20
) (
  input  logic [PN_W-1:0] req_page,
  input  logic [PN_W-1:0] cur_page,
  output logic            in_window
);

  localparam logic [PN_W-1:0] ONE = {{(PN_W-1){1'b0}}, 1'b1};

  logic [PN_W-1:0] next_page;

  assign next_page = cur_page + ONE;
  assign in_window = (req_page == cur_page) || (req_page == next_page);

endmodule

// File: rtl/mmu_bypass_unit.sv
module mmu_bypass_unit
  import mmu_bypass_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PID_W     = 7,
  parameter int PAGE_BITS = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_wr_en,
  input  logic                      cfg_sel,
  input  logic [PID_W-1:0]          cfg_wdata,
  input  logic                      req_valid,
  input  logic                      req_is_instr,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [ADDR_W-PAGE_BITS-1:0] seq_page,
  input  logic                      mnt_req_valid,
  input  logic                      mnt_req_tlb,
  input  logic [ADDR_W-1:0]         mnt_req_addr,
  output logic [2:0]                ctl_state,
  output logic                      pid_err,
  output logic                      rsp_valid,
  output logic                      rsp_is_instr,
  output logic [ADDR_W-1:0]         rsp_paddr,
  output logic [1:0]                rsp_mem_type,
  output logic [1:0]                rsp_inner,
  output logic [1:0]                rsp_outer,
  output logic                      rsp_shareable,
  output logic                      rsp_passthru,
  output logic                      rsp_fetch_ok,
  output logic                      rsp_abort,
  output logic                      mnt_valid,
  output logic                      mnt_tlb,
  output logic [ADDR_W-1:0]         mnt_addr,
  output logic                      mnt_global,
  output logic                      mnt_passthru
);

  localparam int PN_W = ADDR_W - PAGE_BITS;

  ctrl_t ctrl_q;
  attr_t byp_attr;
  logic  win_ok;

  mbu_ctrl_regs #(.PID_W(PID_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (cfg_wr_en),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .ctrl_q (ctrl_q),
    .err_q  (pid_err)
  );

  mbu_attr_sel u_attr (
    .is_instr (req_is_instr),
    .icache   (ctrl_q.icache),
    .attr     (byp_attr)
  );

  mbu_fetch_window #(.PN_W(PN_W)) u_win (
    .req_page  (req_addr[ADDR_W-1:PAGE_BITS]),
    .cur_page  (seq_page),
    .in_window (win_ok)
  );

  assign ctl_state = {ctrl_q.remap, ctrl_q.icache, ctrl_q.xlat};
  assign rsp_abort = 1'b0;

  // Access response: mode is the control state at the accepting edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_is_instr  <= 1'b0;
      rsp_paddr     <= '0;
      rsp_mem_type  <= '0;
      rsp_inner     <= '0;
      rsp_outer     <= '0;
      rsp_shareable <= 1'b0;
      rsp_passthru  <= 1'b0;
      rsp_fetch_ok  <= 1'b0;
    end else begin
      rsp_valid    <= req_valid;
      rsp_is_instr <= req_is_instr;
      rsp_paddr    <= req_addr;
      if (ctrl_q.xlat) begin
        rsp_mem_type  <= '0;
        rsp_inner     <= '0;
        rsp_outer     <= '0;
        rsp_shareable <= 1'b0;
        rsp_passthru  <= 1'b1;
        rsp_fetch_ok  <= 1'b0;
      end else begin
        rsp_mem_type  <= byp_attr.mtype;
        rsp_inner     <= byp_attr.inner;
        rsp_outer     <= byp_attr.outer;
        rsp_shareable <= byp_attr.shareable;
        rsp_passthru  <= 1'b0;
        rsp_fetch_ok  <= req_is_instr ? win_ok : 1'b1;
      end
    end
  end

  // Maintenance path: accepted in both modes, flat and global in bypass.
  always_ff @(posedge clk) begin
    if (rst) begin
      mnt_valid    <= 1'b0;
      mnt_tlb      <= 1'b0;
      mnt_addr     <= '0;
      mnt_global   <= 1'b0;
      mnt_passthru <= 1'b0;
    end else begin
      mnt_valid    <= mnt_req_valid;
      mnt_tlb      <= mnt_req_tlb;
      mnt_addr     <= mnt_req_addr;
      mnt_global   <= !ctrl_q.xlat;
      mnt_passthru <= ctrl_q.xlat;
    end
  end

  AST_FLAT_ADDR: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_passthru) |-> (rsp_paddr == $past(req_addr))); // R2
  AST_DATA_STRONG: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_passthru && !rsp_is_instr) |->
      (rsp_mem_type == 2'b00 && rsp_inner == 2'b00 && rsp_outer == 2'b00)); // R3
  AST_INSTR_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_passthru && rsp_is_instr) |->
      (rsp_mem_type == 2'b10 && !rsp_shareable)); // R6
  AST_PT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_passthru) |->
      (rsp_mem_type == 2'b00 && rsp_inner == 2'b00 && rsp_outer == 2'b00 &&
       !rsp_shareable && !rsp_fetch_ok)); // R11
  AST_WINDOW_REJECT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_is_instr && !rsp_passthru && !rsp_fetch_ok) |->
      ($past(req_addr[ADDR_W-1:PAGE_BITS]) != $past(seq_page))); // R9
  AST_MNT_GLOBAL: assert property (@(posedge clk) disable iff (rst)
    mnt_valid |-> (mnt_global != mnt_passthru)); // R10

endmodule

// File: tb/sim_mmu_bypass_unit.sv
module sim_mmu_bypass_unit;
  localparam int AW = 32;
  localparam int PW = 7;
  localparam int NW = AW - 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic          cfg_wr_en = 0, cfg_sel = 0;
  logic [PW-1:0] cfg_wdata = '0;
  logic          req_valid = 0, req_is_instr = 0;
  logic [AW-1:0] req_addr = '0;
  logic [NW-1:0] seq_page = '0;
  logic          mnt_req_valid = 0, mnt_req_tlb = 0;
  logic [AW-1:0] mnt_req_addr = '0;
  logic [2:0]    ctl_state;
  logic          pid_err, rsp_valid, rsp_is_instr;
  logic [AW-1:0] rsp_paddr;
  logic [1:0]    rsp_mem_type, rsp_inner, rsp_outer;
  logic          rsp_shareable, rsp_passthru, rsp_fetch_ok, rsp_abort;
  logic          mnt_valid, mnt_tlb, mnt_global, mnt_passthru;
  logic [AW-1:0] mnt_addr;

  mmu_bypass_unit #(.ADDR_W(AW), .PID_W(PW), .PAGE_BITS(12)) u0 (.*);

  typedef struct {
    logic [AW-1:0] paddr;
    logic [1:0]    mt, inn, out;
    logic          sh, pt, fok;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  // bench model of the configuration
  logic          m_xlat = 0, m_ic = 0, m_rm = 0;
  logic [PW-1:0] m_pid = '0;

  function automatic exp_t predict(logic [AW-1:0] a, logic ins, logic [NW-1:0] sp, string tag);
    exp_t e;
    logic [NW-1:0] pa;
    pa = a[AW-1:12];
    e.paddr = a; e.tag = tag;
    if (m_xlat) begin
      e.mt = 0; e.inn = 0; e.out = 0; e.sh = 0; e.pt = 1; e.fok = 0;
    end else if (ins) begin
      e.mt = 2'b10; e.inn = m_ic ? 2'b10 : 2'b00; e.out = e.inn; e.sh = 0; e.pt = 0;
      e.fok = (pa == sp) || (pa == NW'(sp + 1));
    end else begin
      e.mt = 2'b00; e.inn = 0; e.out = 0; e.sh = 1; e.pt = 0; e.fok = 1;
    end
    return e;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // driver: one access per call, optional same-edge control write
  task automatic issue(logic [AW-1:0] a, logic ins, logic [NW-1:0] sp, string tag,
                       logic wr = 0, logic [PW-1:0] wd = '0);
    @(negedge clk);
    req_valid = 1; req_is_instr = ins; req_addr = a; seq_page = sp;
    mnt_req_valid = 0;
    cfg_wr_en = wr; cfg_sel = 0; cfg_wdata = wd;
    exp_q.push_back(predict(a, ins, sp, tag));
    if (wr) begin m_xlat = wd[0]; m_ic = wd[1]; m_rm = wd[2]; end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 0; cfg_wr_en = 0; mnt_req_valid = 0;
    end
  endtask

  task automatic cfg_write(logic sel, logic [PW-1:0] d);
    @(negedge clk);
    req_valid = 0; mnt_req_valid = 0;
    cfg_wr_en = 1; cfg_sel = sel; cfg_wdata = d;
    if (sel) m_pid = d;
    else begin m_xlat = d[0]; m_ic = d[1]; m_rm = d[2]; end
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic maint(logic tlb, logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 0; cfg_wr_en = 0;
    mnt_req_valid = 1; mnt_req_tlb = tlb; mnt_req_addr = a;
    @(negedge clk);
    mnt_req_valid = 0;
    chk("R10 mnt_valid", 64'(mnt_valid), 64'd1);
    chk("R10 mnt_tlb", 64'(mnt_tlb), 64'(tlb));
    chk("R10 mnt_addr", 64'(mnt_addr), 64'(a));
    chk("R10 mnt_global", 64'(mnt_global), 64'(!m_xlat));
    chk("R10 mnt_passthru", 64'(mnt_passthru), 64'(m_xlat));
  endtask

  // monitor: pops expected items as responses appear
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL unexpected response actual=%0h expected=none", rsp_paddr);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (rsp_paddr !== e.paddr || rsp_mem_type !== e.mt || rsp_inner !== e.inn ||
            rsp_outer !== e.out || rsp_shareable !== e.sh || rsp_passthru !== e.pt ||
            rsp_fetch_ok !== e.fok || rsp_abort !== 1'b0) begin
          n_fail++;
          $display("FAIL %s actual=%h/%b/%b/%b/%b/%b/%b/%b expected=%h/%b/%b/%b/%b/%b/%b/0",
            e.tag, rsp_paddr, rsp_mem_type, rsp_inner, rsp_outer, rsp_shareable,
            rsp_passthru, rsp_fetch_ok, rsp_abort,
            e.paddr, e.mt, e.inn, e.out, e.sh, e.pt, e.fok);
        end
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 ctl_state", 64'(ctl_state), 64'd0);
    chk("R1 pid_err", 64'(pid_err), 64'd0);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 mnt_valid", 64'(mnt_valid), 64'd0);

    // bypass data accesses: flat address, strongly-ordered (R2 R3 R7)
    issue(32'h0000_0000, 0, 20'h0, "R2 R3 data zero");
    issue(32'hDEAD_BEEF, 0, 20'h0, "R2 R3 data mid");
    issue(32'hFFFF_FFFC, 0, 20'h0, "R2 R3 R7 data top");
    // instruction fetches, caching off, window corners (R4 R6 R9 R7)
    issue(32'h1234_5678, 1, 20'h12345, "R4 R6 R9 same page");
    issue(32'h1234_6000, 1, 20'h12345, "R4 R9 next page");
    issue(32'h1234_4FFC, 1, 20'h12345, "R9 R7 page below rejected");
    issue(32'h1234_7000, 1, 20'h12345, "R9 R7 two pages ahead rejected");
    issue(32'h0000_0010, 1, 20'hFFFFF, "R9 wrap top to page 0");
    idle(3);

    // caching on (R5 R12)
    cfg_write(0, 7'b0000010);
    chk("R12 ctl_state icache", 64'(ctl_state), 64'b010);
    issue(32'h0040_0100, 1, 20'h00400, "R5 R6 cached fetch");
    issue(32'h0040_0200, 0, 20'h00400, "R3 data unaffected by icache");
    // enable translation on the same edge as a request (R12)
    issue(32'h0040_0300, 1, 20'h00400, "R12 old mode on write edge", 1, 7'b0000111);
    issue(32'h0040_0400, 1, 20'h00400, "R11 R12 new mode after write");
    issue(32'h8000_0000, 0, 20'h0, "R11 data forwarded");
    issue(32'h9999_0000, 1, 20'h00400, "R11 R7 out-of-window in translate");
    idle(3);
    chk("R12 ctl_state remap", 64'(ctl_state), 64'b111);

    maint(1, 32'h0ABC_D000);   // translate mode (R10)

    // process-ID error (R8)
    cfg_write(1, 7'd5);
    chk("R8 pid with translate on", 64'(pid_err), 64'd0);
    cfg_write(0, 7'b0000000);
    chk("R8 translate off with pid set", 64'(pid_err), 64'd1);
    cfg_write(1, 7'd0);
    chk("R8 pid cleared", 64'(pid_err), 64'd0);
    cfg_write(1, 7'd127);
    chk("R8 pid written in bypass", 64'(pid_err), 64'd1);
    cfg_write(0, 7'b0000001);
    chk("R8 translate on clears error", 64'(pid_err), 64'd0);
    cfg_write(1, 7'd0);
    cfg_write(0, 7'b0000000);
    chk("R8 bypass pid zero", 64'(pid_err), 64'd0);

    maint(0, 32'h5555_4440);   // bypass mode (R10)
    maint(1, 32'hFFFF_F000);

    issue(32'h7777_7777, 0, 20'h0, "R2 R3 back to bypass");
    issue(32'h0000_1FFC, 1, 20'h00000, "R4 R9 last word of next page");
    idle(4);
    chk("R2 queue drained", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule